// File: doc/BRIEF.md
# Operate Execution Unit with Register File and Condition Flags

This block carries out the three arithmetic/logic operate instructions of a 16-bit load/store instruction set. It holds eight 16-bit general registers, reads up to two of them, computes a sum, a bitwise AND or a bitwise complement, and writes the result back into a destination register on the next rising clock edge. Every register write also sets a sign/zero condition code. The code is exposed as three flags for a neighbouring branch unit.

A second write path lets the surrounding pipeline, such as a load unit, place a value in any register. Writes through this path also update the condition code. An instruction word whose top four bits are not an operate opcode is ignored, as is a word presented without its valid strobe. The written register index and value are presented on the result outputs in the same cycle that the register file and flags change.

Top module: `opx_unit`

## Requirements
- R1: After reset, `cc_z` is 1, `cc_n` and `cc_p` are 0, `res_valid` is 0, and all eight registers read as zero.
- R2: With `instr_valid` high, an instruction with bits [15:12]=0001 and bit 5=0 writes Rd = Rs1 + Rs2 modulo 2^16, where Rd is bits [11:9], Rs1 is bits [8:6] and Rs2 is bits [2:0]. Encoding 0x16C4 stores R3+R4 into R3.
- R3: When bit 5=1, the second operand is bits [4:0] sign-extended to 16 bits, so 11111 means -1. Encoding 0x14BF decrements R2.
- R4: Opcode 0101 writes the bitwise AND of Rs1 and the second operand, chosen by bit 5 as in R2/R3. Encoding 0x56E0 clears R3.
- R5: Opcode 1001 writes the bitwise complement of Rs1 (bits [8:6]) into Rd.
- R6: Each register write sets exactly one flag. `cc_n` is set when bit 15 of the written value is 1, `cc_z` when the value is zero, and `cc_p` otherwise.
- R7: A word with any other opcode, or any word while `instr_valid` is low, changes no register and no flag. In that cycle `res_valid` stays low unless the write-back path is used.
- R8: With `wb_en` high and no operate instruction in the same cycle, `wb_data` is written to register `wb_addr`, and the flags follow R6.
- R9: When a valid operate instruction and `wb_en` arrive in the same cycle, the instruction's write is performed and the write-back request is dropped.
- R10: `res_valid`, `res_addr`, `res_data` and the flags change on the same edge as the register write. A source read one cycle later sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present |
| instr | input | 16 | Instruction word |
| wb_en | input | 1 | Write-back request |
| wb_addr | input | 3 | Write-back register index |
| wb_data | input | 16 | Write-back value |
| res_valid | output | 1 | A register was written on the last edge |
| res_addr | output | 3 | Index of the register written |
| res_data | output | 16 | Value written |
| cc_n | output | 1 | Last written value was negative |
| cc_z | output | 1 | Last written value was zero |
| cc_p | output | 1 | Last written value was positive |

## Verification
Several properties are checked on every cycle:
- exactly one flag is set;
- the flags agree with the sign and zero-ness of the reported result;
- the flags hold when nothing is written;
- a written register holds the written value;
- a collision reports the instruction's destination.

The arithmetic itself needs the bench's reference model: wrap-around sums, sign-extended immediates, complement, and the known encodings. So does the proof that ignored opcodes leave registers untouched, which the bench shows by reading every register back through the operate path.

// File: rtl/opx_pkg.sv
`timescale 1ns/1ps
package opx_pkg;
   localparam int INSTR_W    = 16;
   localparam int OPC_W      = 4;
   localparam int REG_FLD_W  = 3;
   localparam int IMM_W      = 5;

   localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
   localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
   localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

   typedef enum logic [1:0] {
      K_ADD = 2'd0,
      K_AND = 2'd1,
      K_NOT = 2'd2
   } alu_kind_e;
endpackage

// File: rtl/opx_decode.sv
`timescale 1ns/1ps
module opx_decode
   import opx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid,
   input  logic [INSTR_W-1:0]   instr,
   output logic                 op_we,
   output alu_kind_e            kind,
   output logic [REG_FLD_W-1:0] dst,
   output logic [REG_FLD_W-1:0] src1,
   output logic [REG_FLD_W-1:0] src2,
   output logic                 use_imm,
   output logic [DATA_W-1:0]    imm
);
   localparam int EXT_W = DATA_W - IMM_W;

   if (DATA_W <= IMM_W) begin : g_bad_width
      $error("opx_decode: DATA_W must exceed the immediate width");
   end

   logic [OPC_W-1:0] opc;
   logic             known;

   assign opc     = instr[INSTR_W-1 -: OPC_W];
   assign dst     = instr[11:9];
   assign src1    = instr[8:6];
   assign src2    = instr[2:0];
   assign use_imm = instr[5];
   assign imm     = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};

   always_comb begin
      known = 1'b1;
      kind  = K_ADD;
      unique case (opc)
         OPC_ADD: kind = K_ADD;
         OPC_AND: kind = K_AND;
         OPC_NOT: kind = K_NOT;
         default: known = 1'b0;
      endcase
   end

   assign op_we = valid && known;

   p_foreign_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && opc != OPC_ADD && opc != OPC_AND && opc != OPC_NOT) |-> !op_we);
endmodule

// File: rtl/opx_regfile.sv
`timescale 1ns/1ps
module opx_regfile #(
   parameter int DATA_W         = 16,
   parameter int NREG           = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(NREG)-1:0]  ra_a,
   input  logic [$clog2(NREG)-1:0]  ra_b,
   output logic [DATA_W-1:0]        rd_a,
   output logic [DATA_W-1:0]        rd_b,
   input  logic                     we,
   input  logic [$clog2(NREG)-1:0]  wa,
   input  logic [DATA_W-1:0]        wd
);
   localparam int AW = $clog2(NREG);

   if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_depth
      $error("opx_regfile: NREG must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] mem [NREG];

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
         end else if (we) begin
            mem[wa] <= wd;
         end
      end
   end else begin : g_noclear
      always_ff @(posedge clk) begin
         if (we) mem[wa] <= wd;
      end
   end

   assign rd_a = mem[ra_a];
   assign rd_b = mem[ra_b];

   p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(wa)] == $past(wd));
endmodule

// File: rtl/opx_alu.sv
`timescale 1ns/1ps
module opx_alu
   import opx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu_kind_e         kind,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);
   always_comb begin
      unique case (kind)
         K_ADD:   y = a + b;
         K_AND:   y = a & b;
         K_NOT:   y = ~a;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/opx_ccr.sv
`timescale 1ns/1ps
module opx_ccr #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] value,
   output logic              n,
   output logic              z,
   output logic              p
);
   logic [2:0] flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= 3'b010;
      end else if (we) begin
         flags[2] <= value[DATA_W-1];
         flags[1] <= (value == '0);
         flags[0] <= !value[DATA_W-1] && (value != '0);
      end
   end

   assign {n, z, p} = flags;

   p_one_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(flags) == 1);
   p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(flags));
endmodule

// File: rtl/opx_unit.sv
`timescale 1ns/1ps
module opx_unit
   import opx_pkg::*;
#(
   parameter int DATA_W         = 16,
   parameter int NREG           = 8,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW            = $clog2(NREG)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 instr_valid,
   input  logic [INSTR_W-1:0]   instr,
   input  logic                 wb_en,
   input  logic [AW-1:0]        wb_addr,
   input  logic [DATA_W-1:0]    wb_data,
   output logic                 res_valid,
   output logic [AW-1:0]        res_addr,
   output logic [DATA_W-1:0]    res_data,
   output logic                 cc_n,
   output logic                 cc_z,
   output logic                 cc_p
);
   if (AW != REG_FLD_W) begin : g_bad_regs
      $error("opx_unit: register count must match the 3-bit register fields");
   end

   logic                 op_we;
   alu_kind_e            kind;
   logic [REG_FLD_W-1:0] dst, src1, src2;
   logic                 use_imm;
   logic [DATA_W-1:0]    imm, rd_a, rd_b, opnd_b, alu_y;
   logic                 rf_we;
   logic [AW-1:0]        rf_wa;
   logic [DATA_W-1:0]    rf_wd;

   opx_decode #(.DATA_W(DATA_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .valid(instr_valid), .instr(instr),
      .op_we(op_we), .kind(kind), .dst(dst), .src1(src1), .src2(src2),
      .use_imm(use_imm), .imm(imm));

   opx_regfile #(.DATA_W(DATA_W), .NREG(NREG), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_rf (
      .clk(clk), .rst_n(rst_n), .ra_a(src1), .ra_b(src2),
      .rd_a(rd_a), .rd_b(rd_b), .we(rf_we), .wa(rf_wa), .wd(rf_wd));

   assign opnd_b = use_imm ? imm : rd_b;

   opx_alu #(.DATA_W(DATA_W)) u_alu (
      .kind(kind), .a(rd_a), .b(opnd_b), .y(alu_y));

   assign rf_we = op_we || wb_en;
   assign rf_wa = op_we ? dst   : wb_addr;
   assign rf_wd = op_we ? alu_y : wb_data;

   opx_ccr #(.DATA_W(DATA_W)) u_ccr (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .value(rf_wd),
      .n(cc_n), .z(cc_z), .p(cc_p));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_addr  <= '0;
         res_data  <= '0;
      end else begin
         res_valid <= rf_we;
         if (rf_we) begin
            res_addr <= rf_wa;
            res_data <= rf_wd;
         end
      end
   end

   p_flag_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (cc_n == res_data[DATA_W-1]) && (cc_z == (res_data == '0)));
   p_collision_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_we && wb_en) |=> res_valid && res_addr == $past(instr[11:9]));
   p_idle_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!instr_valid && !wb_en) |=> !res_valid);
endmodule

// File: tb/opx_unit_bench.sv
`timescale 1ns/1ps
module opx_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [15:0] instr = '0;
   logic        wb_en = 1'b0;
   logic [2:0]  wb_addr = '0;
   logic [15:0] wb_data = '0;
   logic        res_valid;
   logic [2:0]  res_addr;
   logic [15:0] res_data;
   logic        cc_n, cc_z, cc_p;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [15:0] mreg [8];
   logic [2:0]  mflags;

   always #10 clk = ~clk;

   opx_unit u_opx_unit (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
      .res_valid(res_valid), .res_addr(res_addr), .res_data(res_data),
      .cc_n(cc_n), .cc_z(cc_z), .cc_p(cc_p));

   function automatic logic [2:0] flags_of(input logic [15:0] v);
      if (v[15])        return 3'b100;
      else if (v == 0)  return 3'b010;
      else              return 3'b001;
   endfunction

   function automatic bit is_operate(input logic [15:0] w);
      return w[15:12] == 4'h1 || w[15:12] == 4'h5 || w[15:12] == 4'h9;
   endfunction

   function automatic logic [15:0] ref_result(input logic [15:0] w);
      logic [15:0] a, b;
      a = mreg[w[8:6]];
      b = w[5] ? {{11{w[4]}}, w[4:0]} : mreg[w[2:0]];
      case (w[15:12])
         4'h1:    return a + b;
         4'h5:    return a & b;
         default: return ~a;
      endcase
   endfunction

   function automatic string tag_of(input logic [15:0] w, input logic v, input logic we);
      if (v && is_operate(w) && we) return "R9";
      if (!(v && is_operate(w)))    return we ? "R8" : "R7";
      if (w[15:12] == 4'h9)         return "R5";
      if (w[15:12] == 4'h5)         return "R4";
      return w[5] ? "R3" : "R2";
   endfunction

   task automatic step(input logic [15:0] w, input logic v, input logic we,
                       input logic [2:0] wa, input logic [15:0] wd, input string tag);
      logic        e_valid;
      logic [2:0]  e_addr;
      logic [15:0] e_data;
      @(negedge clk);
      instr = w; instr_valid = v; wb_en = we; wb_addr = wa; wb_data = wd;
      e_valid = 1'b0; e_addr = '0; e_data = '0;
      if (v && is_operate(w)) begin
         e_valid = 1'b1; e_addr = w[11:9]; e_data = ref_result(w);
      end else if (we) begin
         e_valid = 1'b1; e_addr = wa; e_data = wd;
      end
      @(posedge clk);
      #5;
      if (e_valid) begin
         mreg[e_addr] = e_data;
         mflags = flags_of(e_data);
      end
      checks++;
      if (res_valid !== e_valid || {cc_n, cc_z, cc_p} !== mflags ||
          (e_valid && (res_addr !== e_addr || res_data !== e_data))) begin
         failures++;
         $display("FAIL %s instr=%h: got valid=%b addr=%0d data=%h nzp=%b, expected valid=%b addr=%0d data=%h nzp=%b",
                  tag, w, res_valid, res_addr, res_data, {cc_n, cc_z, cc_p},
                  e_valid, e_addr, e_data, mflags);
      end
      instr_valid = 1'b0; wb_en = 1'b0;
   endtask

   task automatic read_all(input string tag);
      for (int r = 0; r < 8; r++)
         step({4'h1, r[2:0], r[2:0], 1'b1, 5'b0}, 1'b1, 1'b0, 3'd0, 16'h0, tag);
   endtask

   task automatic load(input logic [2:0] a, input logic [15:0] d);
      step(16'h0000, 1'b0, 1'b1, a, d, "R8");
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0C3A_5EED));
      for (int i = 0; i < 8; i++) mreg[i] = '0;
      mflags = 3'b010;
      repeat (3) @(negedge clk);
      checks++;
      if ({cc_n, cc_z, cc_p} !== 3'b010 || res_valid !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset: got nzp=%b valid=%b, expected nzp=010 valid=0",
                  {cc_n, cc_z, cc_p}, res_valid);
      end
      rst_n = 1'b1;
      read_all("R1");

      // known encodings
      load(3'd2, 16'd12); load(3'd3, 16'd7); load(3'd4, 16'd5);
      step(16'h14BF, 1'b1, 1'b0, 0, 0, "R3");
      step(16'h16C4, 1'b1, 1'b0, 0, 0, "R2");
      step(16'h56E0, 1'b1, 1'b0, 0, 0, "R4");
      // wrap and sign boundaries
      load(3'd0, 16'h7FFF);
      step({4'h1, 3'd1, 3'd0, 1'b1, 5'd1}, 1'b1, 1'b0, 0, 0, "R2");
      load(3'd5, 16'hFFFF);
      step({4'h1, 3'd5, 3'd5, 1'b1, 5'd1}, 1'b1, 1'b0, 0, 0, "R3");
      step({4'h1, 3'd6, 3'd5, 1'b1, 5'b10000}, 1'b1, 1'b0, 0, 0, "R3");
      step({4'h9, 3'd7, 3'd0, 6'b111111}, 1'b1, 1'b0, 0, 0, "R5");
      step({4'h5, 3'd6, 3'd7, 1'b1, 5'b11111}, 1'b1, 1'b0, 0, 0, "R4");
      // back-to-back dependency
      step({4'h1, 3'd1, 3'd1, 1'b1, 5'd3}, 1'b1, 1'b0, 0, 0, "R10");
      step({4'h1, 3'd1, 3'd1, 1'b0, 2'b00, 3'd1}, 1'b1, 1'b0, 0, 0, "R10");
      // ignored words
      step(16'h0405, 1'b1, 1'b0, 0, 0, "R7");
      step(16'hF025, 1'b1, 1'b0, 0, 0, "R7");
      step(16'h16C4, 1'b0, 1'b0, 0, 0, "R7");
      read_all("R7");
      // collision
      step(16'h14BF, 1'b1, 1'b1, 3'd6, 16'hABCD, "R9");
      read_all("R9");

      for (int k = 0; k < 400; k++) begin
         logic [15:0] w;
         logic        v, we;
         int          sel;
         sel = $urandom % 4;
         w[11:0] = $urandom;
         case (sel)
            0: w[15:12] = 4'h1;
            1: w[15:12] = 4'h5;
            2: w[15:12] = 4'h9;
            default: w[15:12] = $urandom;
         endcase
         v  = ($urandom % 8) != 0;
         we = ($urandom % 4) == 0;
         step(w, v, we, $urandom, $urandom, tag_of(w, v, we));
      end
      read_all("R7");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule